// File: doc/BRIEF.md
# Burst-of-Two Double-Data-Rate Late-Write SRAM

This block is a synthesizable static memory with a single shared data bus that moves data on both edges of one clock. A command (read, write or no-operation) and a word-pair address are taken on each rising clock edge. Every access moves exactly two words. The first word is the even word of the pair and the second word is the odd word. A read returns its two words a fixed one and a half cycles after the command. A write takes its two words, each with its own byte-lane mask, during the cycle after the command. The array is updated later, on an internal schedule.

Because written data reaches the array two rising edges after its command, a read issued in the very next cycle would see stale contents. A forwarding path merges the pending write into the read data lane by lane, so every read returns the newest bytes. The internal command tracker is a three-state machine: `ST_IDLE`, `ST_READ` and `ST_WRITE`. On every rising edge it moves to `ST_READ` if a read is requested (whether or not a write is also requested). Otherwise it moves to `ST_WRITE` if a write is requested. Otherwise it moves to `ST_IDLE`. Every state can reach every other state in one edge. Reset forces `ST_IDLE`.

Top module: `b2s_sram`

## Requirements
- R1: `rd_sel`, `wr_sel` and `cmd_addr` are taken only on rising edges of `clk`. A command taken at rising edge c is identified by its values at that edge.
- R2: For a read taken at rising edge c, the first word is on `dq` from the falling edge at c+1.5 until edge c+2. The second word is on `dq` from edge c+2 until the falling edge at c+2.5.
- R3: The first word returned or written is at word index {cmd_addr, 0}. The second is at {cmd_addr, 1}.
- R4: The block drives `dq` only from rising edge c+1 to falling edge c+2.5 of a read taken at c. At all other times it leaves `dq` released (high impedance).
- R5: For a write taken at rising edge c, the first word and its mask are sampled from `dq` and `bw` at rising edge c+1. The second word and its mask are sampled at the falling edge at c+1.5. The array is updated at rising edge c+2.
- R6: Bit b of `bw` set to 1 writes byte lane b (data bits 8b+7 down to 8b) of that word. Bit b set to 0 leaves that lane unchanged.
- R7: A read of a pair whose write command was taken at the immediately preceding rising edge returns the newly written lanes merged over the old contents.
- R8: When `rd_sel` and `wr_sel` are both 1, the command is a read. The write is ignored: no data is taken and the array is unchanged.
- R9: When both selects are 0, the cycle is a no-operation: nothing is driven on `dq` for it and the array is unchanged.
- R10: Reads may be issued on consecutive edges, giving a gap-free stream of words. A read may directly follow a write with no idle cycle. A write must not directly follow a read.
- R11: While `rst_n` is 0, the command pipeline is cleared and `dq` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. Commands on rising edges; data on both edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel | input | 1 | Read request, active high |
| wr_sel | input | 1 | Write request, active high |
| cmd_addr | input | ADDR_W | Word-pair address (word index without its low bit) |
| bw | input | DATA_W/8 | Byte-lane write enables for the write word being sampled |
| dq | inout | DATA_W | Shared double-data-rate data bus |

## Verification
The bench builds the block with its defaults: a 7-bit pair address (256 words) and a 16-bit bus with two byte lanes. With two lanes, every one of the four mask patterns per word turns up often in random traffic. With 256 words, the whole array can be filled before any read, so every read has a defined expectation. Random traffic is held to twelve pairs, so a read often lands on the pair written one cycle earlier and exercises the forwarding merge. Every quiet bus window is probed by driving a pattern from the bench and reading it back.

// File: rtl/b2s_pkg.sv
package b2s_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } b2s_state_e;
endpackage

// File: rtl/b2s_cmd_fsm.sv
module b2s_cmd_fsm
    import b2s_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_sel,
    input  logic              wr_sel,
    input  logic [ADDR_W-1:0] cmd_addr,
    output b2s_state_e        state,
    output logic [ADDR_W-1:0] addr_q,
    output logic              launch_rd,
    output logic              take_wr
);
    b2s_state_e state_nx;

    always_comb begin
        unique case ({rd_sel, wr_sel})
            2'b10, 2'b11: state_nx = ST_READ;
            2'b01:        state_nx = ST_WRITE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
        end else begin
            state  <= state_nx;
            addr_q <= cmd_addr;
        end
    end

    always_comb begin
        launch_rd = 1'b0;
        take_wr   = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_READ:  launch_rd = 1'b1;
            ST_WRITE: take_wr   = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/b2s_wr_capture.sv
module b2s_wr_capture #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take_wr,
    input  logic [ADDR_W-1:0]   addr_q,
    input  logic [DATA_W-1:0]   dq_in,
    input  logic [DATA_W/8-1:0] bw,
    output logic                commit,
    output logic [ADDR_W-1:0]   commit_addr,
    output logic [DATA_W-1:0]   wd0,
    output logic [DATA_W/8-1:0] wb0,
    output logic [DATA_W-1:0]   wd1,
    output logic [DATA_W/8-1:0] wb1
);
    // first word: rising edge after the command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            commit      <= 1'b0;
            commit_addr <= '0;
            wd0         <= '0;
            wb0         <= '0;
        end else begin
            commit <= take_wr;
            if (take_wr) begin
                commit_addr <= addr_q;
                wd0         <= dq_in;
                wb0         <= bw;
            end
        end
    end

    // second word: the falling edge that follows
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd1 <= '0;
            wb1 <= '0;
        end else if (commit) begin
            wd1 <= dq_in;
            wb1 <= bw;
        end
    end
endmodule

// File: rtl/b2s_store.sv
module b2s_store #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                commit,
    input  logic [ADDR_W-1:0]   commit_addr,
    input  logic [DATA_W-1:0]   wd0,
    input  logic [DATA_W/8-1:0] wb0,
    input  logic [DATA_W-1:0]   wd1,
    input  logic [DATA_W/8-1:0] wb1,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd0,
    output logic [DATA_W-1:0]   rd1
);
    localparam int LANES = DATA_W / 8;
    localparam int WORDS = 2 ** (ADDR_W + 1);

    logic [DATA_W-1:0] mem [WORDS];
    logic [DATA_W-1:0] arr0, arr1;
    logic              hit;

    always_ff @(posedge clk) begin
        if (commit) begin
            for (int l = 0; l < LANES; l++) begin
                if (wb0[l]) mem[{commit_addr, 1'b0}][l*8 +: 8] <= wd0[l*8 +: 8];
                if (wb1[l]) mem[{commit_addr, 1'b1}][l*8 +: 8] <= wd1[l*8 +: 8];
            end
        end
    end

    assign arr0 = mem[{rd_addr, 1'b0}];
    assign arr1 = mem[{rd_addr, 1'b1}];
    assign hit  = commit && (commit_addr == rd_addr);

    // lane-wise forwarding of the write that commits on this same edge
    for (genvar l = 0; l < LANES; l++) begin : g_fwd
        assign rd0[l*8 +: 8] = (hit && wb0[l]) ? wd0[l*8 +: 8] : arr0[l*8 +: 8];
        assign rd1[l*8 +: 8] = (hit && wb1[l]) ? wd1[l*8 +: 8] : arr1[l*8 +: 8];
    end
endmodule

// File: rtl/b2s_rd_drive.sv
module b2s_rd_drive #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch_rd,
    input  logic [DATA_W-1:0] rd0,
    input  logic [DATA_W-1:0] rd1,
    output logic [DATA_W-1:0] dq_out,
    output logic              drive_en
);
    logic [DATA_W-1:0] buf0, buf1, half_lo, half_hi;
    logic              oe_head, oe_tail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_head <= 1'b0;
            buf0    <= '0;
            buf1    <= '0;
            half_hi <= '0;
        end else begin
            oe_head <= launch_rd;
            half_hi <= buf1;
            if (launch_rd) begin
                buf0 <= rd0;
                buf1 <= rd1;
            end
        end
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_tail <= 1'b0;
            half_lo <= '0;
        end else begin
            oe_tail <= oe_head;
            half_lo <= buf0;
        end
    end

    // low phase shows the first word, high phase the second
    assign dq_out   = clk ? half_hi : half_lo;
    assign drive_en = oe_head | oe_tail;
endmodule

// File: rtl/b2s_sram.sv
module b2s_sram
    import b2s_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_sel,
    input  logic                wr_sel,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic [DATA_W/8-1:0] bw,
    inout  wire  [DATA_W-1:0]   dq
);
    b2s_state_e          state;
    logic [ADDR_W-1:0]   addr_q, commit_addr;
    logic                launch_rd, take_wr, commit, drive_en;
    logic [DATA_W-1:0]   wd0, wd1, rd0, rd1, dq_out, dq_in;
    logic [DATA_W/8-1:0] wb0, wb1;

    assign dq_in = dq;
    assign dq    = drive_en ? dq_out : 'z;

    b2s_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .wr_sel(wr_sel),
        .cmd_addr(cmd_addr), .state(state), .addr_q(addr_q),
        .launch_rd(launch_rd), .take_wr(take_wr)
    );

    b2s_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk(clk), .rst_n(rst_n), .take_wr(take_wr), .addr_q(addr_q),
        .dq_in(dq_in), .bw(bw), .commit(commit), .commit_addr(commit_addr),
        .wd0(wd0), .wb0(wb0), .wd1(wd1), .wb1(wb1)
    );

    b2s_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .commit(commit), .commit_addr(commit_addr),
        .wd0(wd0), .wb0(wb0), .wd1(wd1), .wb1(wb1),
        .rd_addr(addr_q), .rd0(rd0), .rd1(rd1)
    );

    b2s_rd_drive #(.DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .launch_rd(launch_rd),
        .rd0(rd0), .rd1(rd1), .dq_out(dq_out), .drive_en(drive_en)
    );
endmodule

// File: rtl/b2s_sram_chk.sv
module b2s_sram_chk
    import b2s_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rd_sel,
    input logic       wr_sel,
    input logic       drive_en,
    input logic       commit,
    input b2s_state_e state
);
    // R4
    oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (drive_en == $past(rd_sel, 2)));

    // R5
    late_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (commit == $past(wr_sel && !rd_sel, 2)));

    // R8
    read_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sel |=> (state == ST_READ));

    // R9
    nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_sel && !wr_sel) |=> ##1 (!drive_en && !commit));
endmodule

bind b2s_sram b2s_sram_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .wr_sel(wr_sel),
    .drive_en(drive_en), .commit(commit), .state(state)
);

// File: tb/b2s_sram_test.sv
`timescale 1ns/100ps
module b2s_sram_test;
    localparam int AW = 7;
    localparam int DW = 16;
    localparam int NB = DW / 8;
    localparam int NW = 2 ** (AW + 1);
    localparam logic [DW-1:0] PROBE = 16'hA55A;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_sel = 1'b0, wr_sel = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [NB-1:0] bw = '0;
    logic [DW-1:0] tb_dq = '0;
    logic          tb_en = 1'b0;
    wire  [DW-1:0] dq;

    assign dq = tb_en ? tb_dq : 'z;

    b2s_sram #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .wr_sel(wr_sel),
        .cmd_addr(cmd_addr), .bw(bw), .dq(dq)
    );

    always #5 clk = ~clk;

    int    n_cmp = 0, n_bad = 0, cyc = 0;
    bit    done = 0;
    string tag = "R11";

    // slot per command edge, modulo 4: kind 0 idle, 1 read, 2 write
    int            s_kind [4];
    logic [DW-1:0] s_e0 [4], s_e1 [4], s_w0 [4], s_w1 [4];
    logic [NB-1:0] s_b0 [4], s_b1 [4];
    logic [DW-1:0] ref_mem [NW];

    task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s [%s] cycle %0d: actual %h expected %h", what, tag, cyc, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                            input logic [NB-1:0] be);
        logic [DW-1:0] r = old;
        for (int l = 0; l < NB; l++) if (be[l]) r[l*8 +: 8] = nw[l*8 +: 8];
        return r;
    endfunction

    // one clock cycle, entered 0.5 ns after a rising edge; the command is taken at the next edge
    task automatic step(input int kind, input int a, input logic [NB-1:0] b0, input logic [NB-1:0] b1);
        int  sl, eff, ev, od;
        bit  probing;
        #2;
        if (s_kind[(cyc+2)%4] == 1) check(dq, s_e1[(cyc+2)%4], "R2 R3 second word");
        if (s_kind[(cyc+3)%4] == 2) begin
            tb_en = 1'b1; tb_dq = s_w1[(cyc+3)%4]; bw = s_b1[(cyc+3)%4];
        end
        sl  = (cyc + 1) % 4;
        eff = (kind == 3) ? 1 : kind;
        ev  = (a * 2) % NW;
        od  = ev + 1;
        s_kind[sl] = eff;
        s_w0[sl] = DW'($urandom);
        s_w1[sl] = DW'($urandom);
        s_b0[sl] = b0;
        s_b1[sl] = b1;
        if (eff == 1) begin
            s_e0[sl] = ref_mem[ev];
            s_e1[sl] = ref_mem[od];
        end
        if (eff == 2) begin
            ref_mem[ev] = merge(ref_mem[ev], s_w0[sl], b0);
            ref_mem[od] = merge(ref_mem[od], s_w1[sl], b1);
        end
        rd_sel   = (kind == 1 || kind == 3);
        wr_sel   = (kind == 2 || kind == 3);
        cmd_addr = AW'(a);
        #5;
        probing = 0;
        if (s_kind[(cyc+3)%4] == 1) check(dq, s_e0[(cyc+3)%4], "R2 R3 first word");
        if (s_kind[cyc%4] == 2) begin
            tb_en = 1'b1; tb_dq = s_w0[cyc%4]; bw = s_b0[cyc%4];
        end else begin
            tb_en = 1'b0; bw = '0;
            if (s_kind[(cyc+3)%4] != 1) begin
                tb_en = 1'b1; tb_dq = PROBE ^ DW'(cyc); probing = 1;
            end
        end
        #1;
        if (probing) begin
            check(dq, PROBE ^ DW'(cyc), "R4 R9 bus released");
            tb_en = 1'b0;
        end
        #2;
        cyc++;
    endtask

    initial begin
        int k, pk;
        for (int s = 0; s < 4; s++) s_kind[s] = 0;
        for (int w = 0; w < NW; w++) ref_mem[w] = '0;
        @(posedge clk);
        #0.5;
        tag = "R11 reset";
        for (int j = 0; j < 3; j++) step(0, 0, '0, '0);
        rst_n = 1'b1;
        step(0, 0, '0, '0);

        tag = "R1 R5 R6 fill";
        for (int a = 0; a < NW/2; a++) step(2, a, '1, '1);

        tag = "R3 R10 read stream";
        for (int a = 0; a < 8; a++) step(1, a, '0, '0);
        step(0, 0, '0, '0);

        tag = "R7 R6 forward";
        step(2, 5, 2'b01, 2'b10);
        step(1, 5, '0, '0);
        step(0, 0, '0, '0);
        step(2, 5, 2'b10, 2'b00);
        step(1, 5, '0, '0);
        step(0, 0, '0, '0);
        step(1, 5, '0, '0);
        step(1, 5, '0, '0);
        step(0, 0, '0, '0);

        tag = "R8 read wins";
        step(3, 9, '1, '1);
        step(0, 0, '0, '0);
        step(1, 9, '0, '0);
        step(0, 0, '0, '0);

        tag = "R9 idle";
        for (int j = 0; j < 4; j++) step(0, 0, '0, '0);
        step(1, 9, '0, '0);
        step(0, 0, '0, '0);

        tag = "R10 R7 random";
        for (int j = 0; j < 600; j++) begin
            k  = int'($urandom % 4);
            pk = s_kind[cyc % 4];
            if ((k == 2) && (pk == 1)) k = 0;
            step(k, int'($urandom % 12), NB'($urandom), NB'($urandom));
        end
        for (int j = 0; j < 4; j++) step(0, 0, '0, '0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog [%s]: actual hung expected finish", tag);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule